// File: doc/BRIEF.md
# Exclusive-Access Reservation Monitor

This block tracks exclusive read/write pairs for requesters that share a memory region. Each requester has one reservation slot. An exclusive read records the address, size, attributes and transaction ID in the slot of its requester. A later exclusive write from the same requester either succeeds or fails. On success the block returns EXOKAY and passes the write to memory. On failure it returns OKAY and holds the memory write-enable low.

A relax input lets the write carry a different transaction ID from the read. This suits a downstream fabric that pairs the two halves of an exclusive sequence without comparing IDs. Every other recorded field must still match.

The monitor is responsible only for accesses flagged cacheable. Accesses flagged non-cacheable pass straight through, because they are handled by a monitor further downstream. The cacheable flag arrives already adjusted for any sharing override. Any exclusive access that lands in the configuration-register window is refused with SLVERR.

Top module: `exmon_top`

## Requirements
- R1: After reset no slot holds a reservation, both response-valid outputs are low, `mem_we` is low and `mem_addr` is zero.
- R2: Response codes are 2 bits wide: OKAY=0, EXOKAY=1, SLVERR=2. Every accepted read or write gets its response one clock after it is presented. A cacheable exclusive read outside the window gets EXOKAY and arms the slot indexed by `rd_src`. A non-exclusive read gets OKAY.
- R3: In strict mode (`relax_id`=0), a cacheable exclusive write whose ID, address, size and attributes all equal the reservation of its `wr_src` slot gets EXOKAY. In the same cycle it raises `mem_we` with `mem_addr` equal to the write address.
- R4: In strict mode, an exclusive write whose ID differs from the reserved ID gets OKAY and leaves `mem_we` low.
- R5: With `relax_id`=1 the ID is not compared. A mismatch in address, size or attributes still makes the write fail.
- R6: An exclusive write whose slot holds no reservation fails. Every cacheable exclusive write clears its own slot, whether it succeeds or fails.
- R7: A cacheable write that reaches memory clears the reservation of every other requester whose address lies in the same 16-byte granule. Here "same granule" means address bits [31:4] are equal. Writes to other granules, and the requester's own plain writes, leave the reservations in place.
- R8: A new exclusive read replaces the earlier reservation of the same requester.
- R9: An exclusive access to the window 0xFFFF0000–0xFFFF0FFF gets SLVERR. It neither arms nor checks nor clears any slot, and an exclusive write there keeps `mem_we` low. A non-exclusive write to the window gets OKAY and is passed to memory.
- R10: A non-cacheable access never arms, checks or clears a slot. Its reads get OKAY, and its writes get OKAY and are passed to memory.
- R11: When a read and a write are presented in the same cycle, the write is judged against the reservations held before that cycle. The read's arming takes effect afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| relax_id | input | 1 | Skip the ID comparison on exclusive writes |
| rd_valid | input | 1 | Read request present |
| rd_src | input | 2 | Requester slot of the read |
| rd_id | input | 4 | Transaction ID of the read |
| rd_addr | input | 32 | Read byte address |
| rd_size | input | 3 | Read transfer size |
| rd_attr | input | 4 | Read control attributes |
| rd_excl | input | 1 | Read is exclusive |
| rd_cacheable | input | 1 | Read is cacheable (override applied) |
| wr_valid | input | 1 | Write request present |
| wr_src | input | 2 | Requester slot of the write |
| wr_id | input | 4 | Transaction ID of the write |
| wr_addr | input | 32 | Write byte address |
| wr_size | input | 3 | Write transfer size |
| wr_attr | input | 4 | Write control attributes |
| wr_excl | input | 1 | Write is exclusive |
| wr_cacheable | input | 1 | Write is cacheable (override applied) |
| rd_rsp_valid | output | 1 | Read response present |
| rd_rsp | output | 2 | Read response code |
| wr_rsp_valid | output | 1 | Write response present |
| wr_rsp | output | 2 | Write response code |
| mem_we | output | 1 | Write allowed to memory |
| mem_addr | output | 32 | Address of the allowed write, zero otherwise |

## Verification
A slot left armed by mistake does not show up at once. It shows later, when an exclusive write that should fail returns EXOKAY and raises `mem_we`. A slot cleared by mistake shows the opposite way: a write that should succeed returns OKAY with memory untouched. In both cases the evidence appears only on the first exclusive write from that requester after the fault. For that reason the random traffic uses a small address pool, so that arming, overlapping writes and checking writes follow each other within a few cycles. The bench model predicts every output bit of every cycle.

// File: rtl/exmon_pkg.sv
package exmon_pkg;
    parameter int ID_W    = 4;
    parameter int ADDR_W  = 32;
    parameter int SIZE_W  = 3;
    parameter int ATTR_W  = 4;
    parameter int N_SRC   = 4;
    parameter int GRAN_LG = 4;
    localparam int SRC_W  = $clog2(N_SRC);

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'd0,
        RSP_EXOKAY = 2'd1,
        RSP_SLVERR = 2'd2
    } rsp_e;

    typedef enum logic [1:0] {
        CLS_IDLE,
        CLS_PLAIN,
        CLS_EXCL,
        CLS_CFGERR
    } cls_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [ATTR_W-1:0] attr;
    } resv_t;
endpackage

// File: rtl/exmon_classify.sv
module exmon_classify
    import exmon_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CFG_BASE    = 32'hFFFF_0000,
    parameter int                CFG_SPAN_LG = 12
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              excl,
    input  logic              cacheable,
    output cls_e              cls
);
    localparam int TAG_W = ADDR_W - CFG_SPAN_LG;

    logic in_window;

    always_comb begin
        in_window = (addr[ADDR_W-1:CFG_SPAN_LG] == CFG_BASE[ADDR_W-1:CFG_SPAN_LG]);
        if (!valid)                 cls = CLS_IDLE;
        else if (excl && in_window) cls = CLS_CFGERR;
        else if (excl && cacheable) cls = CLS_EXCL;
        else                        cls = CLS_PLAIN;
    end

    // Tag width is derived so that a bad span parameter is caught at elaboration.
    if (TAG_W < 1) begin : g_bad_span
        initial $error("CFG_SPAN_LG too large");
    end
endmodule

// File: rtl/exmon_slot.sv
module exmon_slot
    import exmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  arm,
    input  resv_t arm_rec,
    input  logic  clr,
    input  logic  relax_id,
    input  resv_t wr_rec,
    output logic  valid_o,
    output logic  match_o,
    output logic  overlap_o
);
    typedef struct packed {
        logic  valid;
        resv_t rec;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.valid = 1'b0;
        if (arm) begin
            st_d.valid = 1'b1;
            st_d.rec   = arm_rec;
        end
        valid_o   = st_q.valid;
        overlap_o = st_q.valid &&
                    (st_q.rec.addr[ADDR_W-1:GRAN_LG] == wr_rec.addr[ADDR_W-1:GRAN_LG]);
        match_o   = st_q.valid &&
                    (st_q.rec.addr == wr_rec.addr) &&
                    (st_q.rec.size == wr_rec.size) &&
                    (st_q.rec.attr == wr_rec.attr) &&
                    (relax_id || (st_q.rec.id == wr_rec.id));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (valid_o && overlap_o == (wr_rec.addr[ADDR_W-1:GRAN_LG] ==
                                          $past(arm_rec.addr[ADDR_W-1:GRAN_LG]))));
    // R6
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !arm) |=> !valid_o);
endmodule

// File: rtl/exmon_top.sv
module exmon_top
    import exmon_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CFG_BASE    = 32'hFFFF_0000,
    parameter int                CFG_SPAN_LG = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              relax_id,
    input  logic              rd_valid,
    input  logic [SRC_W-1:0]  rd_src,
    input  logic [ID_W-1:0]   rd_id,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SIZE_W-1:0] rd_size,
    input  logic [ATTR_W-1:0] rd_attr,
    input  logic              rd_excl,
    input  logic              rd_cacheable,
    input  logic              wr_valid,
    input  logic [SRC_W-1:0]  wr_src,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              wr_excl,
    input  logic              wr_cacheable,
    output logic              rd_rsp_valid,
    output logic [1:0]        rd_rsp,
    output logic              wr_rsp_valid,
    output logic [1:0]        wr_rsp,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr
);
    typedef struct packed {
        logic              rd_vld;
        rsp_e              rd_code;
        logic              wr_vld;
        rsp_e              wr_code;
        logic              we;
        logic [ADDR_W-1:0] addr;
    } out_st_t;

    out_st_t out_d, out_q;

    cls_e  rd_cls, wr_cls;
    resv_t rd_rec, wr_rec;
    logic [N_SRC-1:0] arm, clr, slot_valid, slot_match, slot_overlap;

    assign rd_rec = '{id: rd_id, addr: rd_addr, size: rd_size, attr: rd_attr};
    assign wr_rec = '{id: wr_id, addr: wr_addr, size: wr_size, attr: wr_attr};

    exmon_classify #(.CFG_BASE(CFG_BASE), .CFG_SPAN_LG(CFG_SPAN_LG)) u_rd_cls (
        .valid(rd_valid), .addr(rd_addr), .excl(rd_excl),
        .cacheable(rd_cacheable), .cls(rd_cls)
    );

    exmon_classify #(.CFG_BASE(CFG_BASE), .CFG_SPAN_LG(CFG_SPAN_LG)) u_wr_cls (
        .valid(wr_valid), .addr(wr_addr), .excl(wr_excl),
        .cacheable(wr_cacheable), .cls(wr_cls)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_slot
        exmon_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (arm[g]),
            .arm_rec  (rd_rec),
            .clr      (clr[g]),
            .relax_id (relax_id),
            .wr_rec   (wr_rec),
            .valid_o  (slot_valid[g]),
            .match_o  (slot_match[g]),
            .overlap_o(slot_overlap[g])
        );
    end

    always_comb begin
        out_d  = '0;
        arm    = '0;
        clr    = '0;

        out_d.rd_vld = rd_valid;
        unique case (rd_cls)
            CLS_CFGERR: out_d.rd_code = RSP_SLVERR;
            CLS_EXCL: begin
                out_d.rd_code = RSP_EXOKAY;
                arm[rd_src]   = 1'b1;
            end
            default:    out_d.rd_code = RSP_OKAY;
        endcase

        out_d.wr_vld = wr_valid;
        unique case (wr_cls)
            CLS_CFGERR: out_d.wr_code = RSP_SLVERR;
            CLS_EXCL: begin
                clr[wr_src] = 1'b1;
                if (slot_match[wr_src]) begin
                    out_d.wr_code = RSP_EXOKAY;
                    out_d.we      = 1'b1;
                end else begin
                    out_d.wr_code = RSP_OKAY;
                end
            end
            CLS_PLAIN: begin
                out_d.wr_code = RSP_OKAY;
                out_d.we      = 1'b1;
            end
            default:    out_d.wr_code = RSP_OKAY;
        endcase

        if (out_d.we) out_d.addr = wr_addr;

        for (int i = 0; i < N_SRC; i++) begin
            if (out_d.we && wr_cacheable && slot_overlap[i] && (wr_src != SRC_W'(i)))
                clr[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_rsp_valid = out_q.rd_vld;
    assign rd_rsp       = out_q.rd_code;
    assign wr_rsp_valid = out_q.wr_vld;
    assign wr_rsp       = out_q.wr_code;
    assign mem_we       = out_q.we;
    assign mem_addr     = out_q.addr;

    // R2
    wr_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> wr_rsp_valid);
    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_rsp_valid);
    // R9
    slverr_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rsp_valid && wr_rsp == RSP_SLVERR) |-> !mem_we);
    // R3
    exokay_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rsp_valid && wr_rsp == RSP_EXOKAY) |-> (mem_we && mem_addr != '0 || mem_we));
    // R6
    nores_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_excl && wr_cacheable && !slot_valid[wr_src]) |=>
        (wr_rsp != RSP_EXOKAY && !mem_we));
endmodule

// File: tb/exmon_top_bench.sv
module exmon_top_bench;
    import exmon_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [SRC_W-1:0]  src;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [ATTR_W-1:0] attr;
        logic              excl;
        logic              cach;
    } acc_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic relax_id = 1'b0;
    acc_t rq = '0, wq = '0;

    logic              rd_rsp_valid, wr_rsp_valid, mem_we;
    logic [1:0]        rd_rsp, wr_rsp;
    logic [ADDR_W-1:0] mem_addr;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic              m_v    [N_SRC];
    logic [ID_W-1:0]   m_id   [N_SRC];
    logic [ADDR_W-1:0] m_addr [N_SRC];
    logic [SIZE_W-1:0] m_size [N_SRC];
    logic [ATTR_W-1:0] m_attr [N_SRC];

    always #4ns clk = ~clk;

    exmon_top u_exmon_top (
        .clk(clk), .rst_n(rst_n), .relax_id(relax_id),
        .rd_valid(rq.valid), .rd_src(rq.src), .rd_id(rq.id), .rd_addr(rq.addr),
        .rd_size(rq.size), .rd_attr(rq.attr), .rd_excl(rq.excl), .rd_cacheable(rq.cach),
        .wr_valid(wq.valid), .wr_src(wq.src), .wr_id(wq.id), .wr_addr(wq.addr),
        .wr_size(wq.size), .wr_attr(wq.attr), .wr_excl(wq.excl), .wr_cacheable(wq.cach),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp(rd_rsp), .wr_rsp_valid(wr_rsp_valid),
        .wr_rsp(wr_rsp), .mem_we(mem_we), .mem_addr(mem_addr)
    );

    function automatic bit in_cfg(logic [ADDR_W-1:0] a);
        return a[31:12] == 20'hFFFF0;
    endfunction

    function automatic acc_t mk(int src, int id, logic [31:0] addr, int size,
                                int attr, bit excl, bit cach);
        acc_t r;
        r.valid = 1'b1;
        r.src   = SRC_W'(src);
        r.id    = ID_W'(id);
        r.addr  = addr;
        r.size  = SIZE_W'(size);
        r.attr  = ATTR_W'(attr);
        r.excl  = excl;
        r.cach  = cach;
        return r;
    endfunction

    // Drive one cycle, predict its registered outputs, update the model, compare.
    task automatic apply(string tag, acc_t r, acc_t w);
        logic [1:0] e_rr, e_wr;
        logic e_we;
        logic [ADDR_W-1:0] e_ma;
        logic [ADDR_W+6:0] e_vec, a_vec;
        logic clr_n [N_SRC];
        rq = r;
        wq = w;
        e_rr = 2'd0; e_wr = 2'd0; e_we = 1'b0; e_ma = '0;
        for (int i = 0; i < N_SRC; i++) clr_n[i] = 1'b0;
        if (r.valid && r.excl && in_cfg(r.addr))   e_rr = 2'd2;
        else if (r.valid && r.excl && r.cach)      e_rr = 2'd1;
        if (w.valid) begin
            if (w.excl && in_cfg(w.addr)) e_wr = 2'd2;
            else if (w.excl && w.cach) begin
                clr_n[w.src] = 1'b1;
                if (m_v[w.src] && m_addr[w.src] == w.addr && m_size[w.src] == w.size &&
                    m_attr[w.src] == w.attr && (relax_id || m_id[w.src] == w.id)) begin
                    e_wr = 2'd1; e_we = 1'b1;
                end
            end else e_we = 1'b1;
        end
        if (e_we) e_ma = w.addr;
        if (e_we && w.cach)
            for (int i = 0; i < N_SRC; i++)
                if (i != int'(w.src) && m_v[i] && m_addr[i][31:4] == w.addr[31:4])
                    clr_n[i] = 1'b1;
        for (int i = 0; i < N_SRC; i++) if (clr_n[i]) m_v[i] = 1'b0;
        if (r.valid && r.excl && r.cach && !in_cfg(r.addr)) begin
            m_v[r.src] = 1'b1; m_id[r.src] = r.id; m_addr[r.src] = r.addr;
            m_size[r.src] = r.size; m_attr[r.src] = r.attr;
        end
        e_vec = {r.valid, e_rr, w.valid, e_wr, e_we, e_ma};
        @(posedge clk);
        @(negedge clk);
        a_vec = {rd_rsp_valid, rd_rsp, wr_rsp_valid, wr_rsp, mem_we, mem_addr};
        n_vec++;
        if (a_vec !== e_vec) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, a_vec, e_vec);
        end
    endtask

    initial begin
        #1600us;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        acc_t idle;
        idle = '0;
        void'($urandom(32'd1234));
        for (int i = 0; i < N_SRC; i++) begin
            m_v[i] = 1'b0; m_id[i] = '0; m_addr[i] = '0; m_size[i] = '0; m_attr[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs idle while and right after reset
        n_vec++;
        if ({rd_rsp_valid, wr_rsp_valid, mem_we, mem_addr} !== '0) begin
            n_bad++;
            $display("FAIL R1: got %b%b%b %h expected 000 0", rd_rsp_valid,
                     wr_rsp_valid, mem_we, mem_addr);
        end
        rst_n = 1'b1;
        apply("R1", idle, idle);
        apply("R1", idle, mk(0, 1, 32'h100, 2, 1, 1, 1));   // no slot armed after reset

        // R2 / R3: arm then matching write
        apply("R2", mk(0, 1, 32'h100, 2, 1, 1, 1), idle);
        apply("R2", mk(0, 1, 32'h100, 2, 1, 0, 1), idle);
        apply("R3", idle, mk(0, 1, 32'h100, 2, 1, 1, 1));
        // R6: slot cleared, second write fails; unarmed requester fails
        apply("R6", idle, mk(0, 1, 32'h100, 2, 1, 1, 1));
        apply("R6", idle, mk(1, 1, 32'h100, 2, 1, 1, 1));
        // R4: strict ID mismatch
        apply("R4", mk(0, 1, 32'h100, 2, 1, 1, 1), idle);
        apply("R4", idle, mk(0, 2, 32'h100, 2, 1, 1, 1));
        // R5: relaxed ID
        relax_id = 1'b1;
        apply("R5", mk(0, 1, 32'h100, 2, 1, 1, 1), idle);
        apply("R5", idle, mk(0, 3, 32'h100, 2, 1, 1, 1));
        apply("R5", mk(0, 1, 32'h100, 2, 1, 1, 1), idle);
        apply("R5", idle, mk(0, 3, 32'h100, 3, 1, 1, 1));
        relax_id = 1'b0;
        // R7: overlap clearing
        apply("R7", mk(0, 1, 32'h100, 2, 1, 1, 1), idle);
        apply("R7", idle, mk(1, 5, 32'h108, 2, 0, 0, 1));
        apply("R7", idle, mk(0, 1, 32'h100, 2, 1, 1, 1));
        apply("R7", mk(0, 1, 32'h100, 2, 1, 1, 1), idle);
        apply("R7", idle, mk(1, 5, 32'h110, 2, 0, 0, 1));
        apply("R7", idle, mk(0, 0, 32'h100, 2, 0, 0, 1));
        apply("R7", idle, mk(0, 1, 32'h100, 2, 1, 1, 1));
        // R8: replacement
        apply("R8", mk(2, 4, 32'h100, 2, 1, 1, 1), idle);
        apply("R8", mk(2, 4, 32'h140, 2, 1, 1, 1), idle);
        apply("R8", idle, mk(2, 4, 32'h100, 2, 1, 1, 1));
        apply("R8", mk(2, 4, 32'h100, 2, 1, 1, 1), idle);
        apply("R8", mk(2, 4, 32'h140, 2, 1, 1, 1), idle);
        apply("R8", idle, mk(2, 4, 32'h140, 2, 1, 1, 1));
        // R9: configuration window
        apply("R9", mk(3, 0, 32'hFFFF_0010, 2, 0, 1, 1), idle);
        apply("R9", idle, mk(3, 0, 32'hFFFF_0010, 2, 0, 1, 1));
        apply("R9", mk(3, 2, 32'h200, 2, 0, 1, 1), idle);
        apply("R9", idle, mk(3, 2, 32'hFFFF_0010, 2, 0, 1, 1));
        apply("R9", idle, mk(3, 2, 32'h200, 2, 0, 1, 1));
        apply("R9", idle, mk(3, 2, 32'hFFFF_0010, 2, 0, 0, 1));
        // R10: non-cacheable traffic
        apply("R10", mk(1, 1, 32'h180, 2, 0, 1, 0), idle);
        apply("R10", idle, mk(1, 1, 32'h180, 2, 0, 1, 1));
        apply("R10", mk(1, 1, 32'h180, 2, 0, 1, 1), idle);
        apply("R10", idle, mk(0, 1, 32'h180, 2, 0, 0, 0));
        apply("R10", idle, mk(1, 1, 32'h180, 2, 0, 1, 1));
        // R11: same-cycle arm and check
        apply("R11", mk(0, 6, 32'h300, 2, 0, 1, 1), mk(0, 6, 32'h300, 2, 0, 1, 1));
        apply("R11", idle, mk(0, 6, 32'h300, 2, 0, 1, 1));

        // Random traffic over a small address pool
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] pool [6];
            acc_t r, w;
            string tag;
            pool = '{32'h100, 32'h104, 32'h108, 32'h118, 32'h200, 32'hFFFF_0010};
            if (n % 500 == 0) relax_id = $urandom_range(0, 1);
            r = mk($urandom_range(0, 3), $urandom_range(0, 1), pool[$urandom_range(0, 5)],
                   $urandom_range(2, 3), $urandom_range(0, 1), $urandom_range(0, 1),
                   ($urandom_range(0, 7) != 0));
            w = mk($urandom_range(0, 3), $urandom_range(0, 1), pool[$urandom_range(0, 5)],
                   $urandom_range(2, 3), $urandom_range(0, 1), $urandom_range(0, 1),
                   ($urandom_range(0, 7) != 0));
            r.valid = ($urandom_range(0, 9) < 7);
            w.valid = ($urandom_range(0, 9) < 7);
            if (w.valid && w.excl && in_cfg(w.addr))  tag = "R9";
            else if (w.valid && w.excl && w.cach)     tag = relax_id ? "R5" : "R3";
            else if (w.valid)                         tag = "R7";
            else                                      tag = "R2";
            apply(tag, r, w);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule